// File: doc/BRIEF.md
# Predicate mask lookup unit

This unit decides which predication mask applies to an operation. Software loads up to four table entries. Each entry is tied to one destination register number plus a flag that says whether the register is integer or floating point. When an operation is issued, the unit searches the table with the operation's destination register. It then reads the selected predicate register through a register-file read port, optionally complements the value, and hands the mask and a zeroing flag to the element-write logic.

An entry arrives in one of two encodings:

- **Full 16-bit encoding.** It names the predicate register explicitly as a 7-bit address.
- **Compact 8-bit encoding.** It names no predicate register. The predicate register is implied by the slot the entry occupies: slot k uses x(9+k).

The search is allowed only under one of two conditions. Either the register-redirection stage reports the destination as active, or the operation is a branch, which bypasses that gate. Applying the mask to element writes happens elsewhere.

Top module: `predmask_lookup`

## Requirements
- R1: After reset every slot is empty. Every lookup then misses: `rf_ren` is 0, `m_mask` is all ones and `m_zero` is 0.
- R2: A slot matches only when both of these hold:
  - its valid bit is set;
  - its 6-bit key and integer/float flag equal `q_rd` and `q_isint`.
  A lookup that matches no slot returns an all-ones mask and `m_zero` 0.
- R3: A full-encoding load (`load_wide`=1) stores the following fields of `load_data`:
  - key bits [4:0] in [4:0] and key bit 5 in [8];
  - integer flag in [5];
  - invert in [6];
  - zeroing in [7];
  - predicate register address in [15:9].
  On a match, `rf_raddr` equals that stored address.
- R4: A compact-encoding load (`load_wide`=0) uses `load_data[7:0]` with the same low-byte fields. Key bit 5 is 0. On a match in slot k, `rf_raddr` is 9+k.
- R5: On a match with invert set, `m_mask` is the bitwise complement of `rf_rdata`. With invert clear, it equals `rf_rdata`. The register file is only read, never written.
- R6: On a match, `m_zero` equals the stored zeroing bit. Zeroing 1 means element positions with a 0 mask bit are written with zero. Zeroing 0 means they are left untouched.
- R7: When `q_reg_active` is 0 and `q_branch` is 0, the table is not consulted: `rf_ren` is 0, `m_mask` is all ones and `m_zero` is 0.
- R8: When `q_branch` is 1, the table is consulted regardless of `q_reg_active`.
- R9: When several slots match, the lowest-numbered slot supplies the address, invert and zeroing.
- R10: `m_valid` is high in exactly the cycle after `q_valid`. `rf_ren` is high only in a cycle where `m_valid` is high and a slot matched.
- R11: Loading a slot that already holds an entry replaces all of its fields, and later lookups use the new entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Write one table slot |
| load_idx | input | 2 | Slot to write |
| load_wide | input | 1 | 1 = full 16-bit encoding, 0 = compact 8-bit |
| load_data | input | 16 | Entry encoding |
| q_valid | input | 1 | Lookup request |
| q_rd | input | 6 | Destination register number |
| q_isint | input | 1 | 1 = integer register, 0 = floating point |
| q_reg_active | input | 1 | Redirection entry for the destination is active |
| q_branch | input | 1 | Operation is a branch |
| rf_ren | output | 1 | Predicate register read enable |
| rf_raddr | output | 7 | Predicate register address |
| rf_rdata | input | 64 | Predicate register contents, same cycle |
| m_valid | output | 1 | Lookup result valid |
| m_mask | output | 64 | Predication mask |
| m_zero | output | 1 | Zeroing mode for the masked-off elements |

## Verification
A corrupted key, flag or valid bit in a slot shows up in the next cycle after any lookup that touches that register:
- a wrongly enabled read;
- a read from the wrong address;
- a mask that is all ones when it should carry data.

A wrong priority or a wrong implied address appears only when duplicate keys or compact slots are present. The sweeps therefore cover every register number under each gating combination, with tables holding both kinds of duplicate.

// File: rtl/predmask_lookup.sv
module predmask_lookup #(
  parameter int N_ENT     = 4,
  parameter int MASK_W    = 64,
  parameter int IMPL_BASE = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_en,
  input  logic [$clog2(N_ENT)-1:0] load_idx,
  input  logic                     load_wide,
  input  logic [15:0]              load_data,
  input  logic                     q_valid,
  input  logic [5:0]               q_rd,
  input  logic                     q_isint,
  input  logic                     q_reg_active,
  input  logic                     q_branch,
  output logic                     rf_ren,
  output logic [6:0]               rf_raddr,
  input  logic [MASK_W-1:0]        rf_rdata,
  output logic                     m_valid,
  output logic [MASK_W-1:0]        m_mask,
  output logic                     m_zero
);
  localparam int KEY_W  = 6;
  localparam int PREG_W = 7;

  logic [N_ENT-1:0] ent_v, ent_wide, ent_int, ent_inv, ent_zero;
  logic [KEY_W-1:0]  ent_key  [N_ENT];
  logic [PREG_W-1:0] ent_pred [N_ENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v    <= '0;
      ent_wide <= '0;
      ent_int  <= '0;
      ent_inv  <= '0;
      ent_zero <= '0;
      for (int i = 0; i < N_ENT; i++) begin
        ent_key[i]  <= '0;
        ent_pred[i] <= '0;
      end
    end else if (load_en) begin
      ent_v[load_idx]    <= 1'b1;
      ent_wide[load_idx] <= load_wide;
      ent_int[load_idx]  <= load_data[5];
      ent_inv[load_idx]  <= load_data[6];
      ent_zero[load_idx] <= load_data[7];
      ent_key[load_idx]  <= {load_wide & load_data[8], load_data[4:0]};
      ent_pred[load_idx] <= load_wide ? load_data[15:9] : '0;
    end
  end

  logic [N_ENT-1:0] hit_vec;
  genvar g;
  generate
    for (g = 0; g < N_ENT; g++) begin : g_match
      assign hit_vec[g] = ent_v[g] && ent_key[g] == q_rd && ent_int[g] == q_isint;
    end
  endgenerate

  logic              open_q, sel_hit, sel_inv, sel_zero;
  logic [PREG_W-1:0] sel_addr;

  assign open_q = q_reg_active | q_branch;

  always_comb begin
    sel_hit  = 1'b0;
    sel_inv  = 1'b0;
    sel_zero = 1'b0;
    sel_addr = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        sel_hit  = 1'b1;
        sel_inv  = ent_inv[i];
        sel_zero = ent_zero[i];
        sel_addr = ent_wide[i] ? ent_pred[i] : PREG_W'(IMPL_BASE + i);
      end
    end
  end

  logic              s_valid, s_hit, s_inv, s_zero;
  logic [PREG_W-1:0] s_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      s_hit   <= 1'b0;
      s_inv   <= 1'b0;
      s_zero  <= 1'b0;
      s_addr  <= '0;
    end else begin
      s_valid <= q_valid;
      s_hit   <= q_valid & open_q & sel_hit;
      s_inv   <= sel_inv;
      s_zero  <= sel_zero;
      s_addr  <= sel_addr;
    end
  end

  assign m_valid  = s_valid;
  assign rf_ren   = s_valid & s_hit;
  assign rf_raddr = s_addr;
  assign m_zero   = rf_ren & s_zero;
  assign m_mask   = !rf_ren ? '1 : (s_inv ? ~rf_rdata : rf_rdata);

  AST_READ_ONLY_WHEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rf_ren |-> m_valid); // R10
  AST_RESULT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |=> m_valid); // R10
  AST_NO_REQ_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |=> !m_valid); // R10
  AST_GATED_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && !q_reg_active && !q_branch |=> !rf_ren); // R7
  AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !rf_ren |-> (&m_mask) && !m_zero); // R2
endmodule

// File: tb/tb_predmask_lookup.sv
module tb_predmask_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [1:0]  load_idx = '0;
  logic        load_wide = 1'b0;
  logic [15:0] load_data = '0;
  logic        q_valid = 1'b0;
  logic [5:0]  q_rd = '0;
  logic        q_isint = 1'b0;
  logic        q_reg_active = 1'b0;
  logic        q_branch = 1'b0;
  logic        rf_ren, m_valid, m_zero;
  logic [6:0]  rf_raddr;
  logic [63:0] rf_rdata, m_mask;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  function automatic logic [63:0] rfv(input logic [6:0] a);
    return (64'(a) + 64'd1) * 64'h9E3779B97F4A7C15;
  endfunction
  assign rf_rdata = rfv(rf_raddr);

  predmask_lookup dut (.*);

  logic       mv[4], mw[4], mi[4], mn[4], mz[4];
  logic [5:0] mk[4];
  logic [6:0] mp[4];

  task automatic ck(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ld(input int idx, input bit wide, input logic [5:0] key, input bit isint,
                    input bit inv, input bit zero, input logic [6:0] pred);
    @(negedge clk);
    load_en   = 1'b1;
    load_idx  = 2'(idx);
    load_wide = wide;
    load_data = {pred, key[5], zero, inv, isint, key[4:0]};
    if (!wide) load_data[15:8] = 8'hA5;
    mv[idx] = 1'b1; mw[idx] = wide; mi[idx] = isint; mn[idx] = inv; mz[idx] = zero;
    mk[idx] = wide ? key : {1'b0, key[4:0]};
    mp[idx] = pred;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic look(input string sw, input logic [5:0] rd, input bit isint, input bit act, input bit br);
    int   hi;
    logic [6:0]  ea;
    logic [63:0] em;
    logic        ez, er;
    string       t;
    q_valid = 1'b1; q_rd = rd; q_isint = isint; q_reg_active = act; q_branch = br;
    hi = -1;
    for (int i = 3; i >= 0; i--)
      if (mv[i] && mk[i] == rd && mi[i] == isint) hi = i;
    er = (act || br) && hi >= 0;
    ea = 7'd0; em = '1; ez = 1'b0;
    if (er) begin
      ea = mw[hi] ? mp[hi] : 7'(9 + hi);
      em = mn[hi] ? ~rfv(ea) : rfv(ea);
      ez = mz[hi];
    end
    t = !(act || br) ? "R7" : (!act ? "R8" : "R2");
    @(negedge clk);
    q_valid = 1'b0;
    ck(m_valid === 1'b1, {sw, "/R10 valid"}, 64'(m_valid), 64'd1);
    ck(rf_ren === er, {sw, "/", t, " ren"}, 64'(rf_ren), 64'(er));
    if (er) begin
      ck(rf_raddr === ea, {sw, mw[hi] ? "/R3" : "/R4", (hi > 0) ? "/R9" : "", " addr"}, 64'(rf_raddr), 64'(ea));
      ck(m_mask === em, {sw, "/R5 mask"}, m_mask, em);
      ck(m_zero === ez, {sw, "/R6 zero"}, 64'(m_zero), 64'(ez));
    end else begin
      ck(m_mask === em && m_zero === 1'b0, {sw, "/", t, " miss"}, m_mask, em);
    end
  endtask

  task automatic sweep(input string sw);
    for (int r = 0; r < 64; r++)
      for (int f = 0; f < 2; f++)
        for (int g = 0; g < 4; g++)
          look(sw, 6'(r), f[0], g[0], g[1]);
    @(negedge clk);
    ck(m_valid === 1'b0, {sw, "/R10 idle"}, 64'(m_valid), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      mv[i] = 0; mw[i] = 0; mi[i] = 0; mn[i] = 0; mz[i] = 0; mk[i] = 0; mp[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ck(m_valid === 1'b0 && rf_ren === 1'b0, "R1 reset outputs", {62'd0, m_valid, rf_ren}, 64'd0);
    sweep("R1");
    ld(0, 1, 6'd3,  1, 0, 1, 7'd40);
    ld(1, 0, 6'd3,  1, 1, 0, 7'd0);
    ld(2, 0, 6'd7,  0, 1, 0, 7'd0);
    ld(3, 1, 6'd37, 0, 1, 1, 7'd127);
    sweep("A");
    ld(0, 0, 6'd3,  1, 0, 0, 7'd0);
    ld(1, 1, 6'd7,  0, 0, 1, 7'd0);
    ld(3, 1, 6'd3,  1, 1, 1, 7'd77);
    sweep("R11");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule